// File: doc/BRIEF.md
# Reset Release Sequencer with Clock-Fail Fallback

This block decides when a chip's internal reset may be lifted after a power-on or a brown-out. It runs on an always-running low-power reference clock, and it measures every delay in cycles of that clock. After a trigger it counts a power-on delay, then a power-up timer delay. When the power-up timer is off but a crystal is selected, a short fixed fail-safe delay replaces it. In parallel it counts an oscillator start-up interval for crystal modes. It then checks whether the selected clock is usable: the oscillator runs, the start-up count has expired when a crystal is used, and the PLL reports lock when the PLL is enabled.

When the clock is ready, reset is released on the primary source. When it is not ready and the clock monitor is enabled, the block releases reset on the fast RC fallback and emits a one-cycle trap pulse. When the monitor is disabled, the block holds reset until the clock becomes ready. Sticky status bits record power-on and brown-out causes until a software clear strobe. The fallback selection stays latched until software writes a new selection.

Top module: `rst_release_seq`

## Requirements
- R1: While `por_i` is high and right after it falls: `rst_int_o`=1, `clk_sel_o`=0 (primary), `trap_o`=0, `stat_por_o`=1, `stat_bor_o`=0.
- R2: With the power-up timer enabled and the clock ready, `rst_int_o` falls at the (POR_CYC+PWRT_CYC+1)-th rising edge after `por_i` falls.
- R3: With the power-up timer disabled and crystal mode selected, release comes at edge POR_CYC+FSCM_CYC+1.
- R4: With the power-up timer disabled and a non-crystal source, release comes at edge POR_CYC+1, and no start-up count is required.
- R5: While the primary source is selected, `sysclk_en_o` is 1 only when the oscillator runs and, in crystal mode, OST_CYC running cycles have been counted since the last trigger; in non-crystal mode it follows `osc_run_i` at once.
- R6: With the PLL enabled and the primary source selected, `sysclk_en_o` stays 0 while `pll_lock_i` is 0.
- R7: With the clock monitor enabled and the clock not ready once the delays expire, reset is released one edge later with `trap_o` high for exactly one cycle, `clk_sel_o`=1 (fallback) and `sysclk_en_o`=1.
- R8: With the clock monitor disabled and the clock not ready, reset stays asserted with no trap. A late crystal start releases reset OST_CYC+1 edges after `osc_run_i` rises. A late PLL lock releases reset 1 edge after `pll_lock_i` rises.
- R9: A `bor_i` pulse in any state sets `stat_bor_o`, asserts reset from the next edge, returns `clk_sel_o` to primary, and restarts the start-up count. Release then comes at edge POR_CYC+L+2, counting the brown-out edge as edge 1, where L is the middle delay of R2–R4.
- R10: `stat_clr_i` clears both status bits at the next edge, except in a cycle where `bor_i` is high; then `stat_bor_o` is set.
- R11: The fallback selection persists until `clksel_wr_i` loads `clksel_wdata_i` into `clk_sel_o` (0 primary, 1 fallback).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running low-power reference clock |
| por_i | input | 1 | Power-on trigger, asynchronous, active high |
| bor_i | input | 1 | Brown-out detect pulse, synchronous |
| xtal_mode_i | input | 1 | Crystal oscillator mode selected |
| pll_en_i | input | 1 | PLL in use |
| pwrt_en_i | input | 1 | Power-up timer enabled |
| fscm_en_i | input | 1 | Clock monitor enabled |
| osc_run_i | input | 1 | Primary oscillator running |
| pll_lock_i | input | 1 | PLL lock indication |
| stat_clr_i | input | 1 | Software strobe clearing status bits |
| clksel_wr_i | input | 1 | Software strobe writing the clock selection |
| clksel_wdata_i | input | 1 | New clock selection, 0 primary, 1 fallback |
| rst_int_o | output | 1 | Internal reset, active high |
| sysclk_en_o | output | 1 | System clock enable |
| clk_sel_o | output | 1 | Clock source select, 0 primary, 1 fast RC |
| trap_o | output | 1 | One-cycle clock-failure trap |
| stat_por_o | output | 1 | Sticky power-on cause |
| stat_bor_o | output | 1 | Sticky brown-out cause |

## Verification
Reset release is due a fixed number of rising edges after the trigger. The count is the power-on delay plus the selected middle delay plus one evaluation edge, and one more when the brown-out edge is included. The bench counts edges one by one and samples on the falling edge, so each measured count is compared with a value it computes from the parameters. The trap pulse and the fallback selection are due on the same edge that lifts reset, and the pulse is gone one edge later. Status bits and software writes take effect at the next edge. The clock enable follows its inputs within the same cycle, apart from the start-up count, which expires after OST_CYC running edges.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [1:0] {
    ST_POR  = 2'd0,
    ST_PWRT = 2'd1,
    ST_WAIT = 2'd2,
    ST_RUN  = 2'd3
  } rrs_state_e;
endpackage

// File: rtl/rrs_ost_ctr.sv
module rrs_ost_ctr #(
  parameter int OST_CYC = 1024
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic restart_i,
  input  logic osc_run_i,
  output logic done_o
);
  localparam int OW = $clog2(OST_CYC + 1);
  localparam logic [OW-1:0] OST_END = OW'(OST_CYC);

  logic [OW-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)                              cnt_q <= '0;
    else if (restart_i)                     cnt_q <= '0;
    else if (osc_run_i && cnt_q != OST_END) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == OST_END);

  // R5
  ost_sticky_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (done_o && !restart_i) |=> done_o);

  // R9
  ost_restart_chk: assert property (@(posedge clk_i) disable iff (por_i)
    restart_i |=> !done_o);
endmodule

// File: rtl/rrs_seq_fsm.sv
module rrs_seq_fsm
  import rrs_pkg::*;
#(
  parameter int POR_CYC  = 64,
  parameter int PWRT_CYC = 2048,
  parameter int FSCM_CYC = 4
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic bor_i,
  input  logic pwrt_en_i,
  input  logic xtal_i,
  input  logic fscm_en_i,
  input  logic clk_ready_i,
  output logic in_reset_o,
  output logic trap_set_o,
  output logic trap_o
);
  localparam int M1   = (POR_CYC > PWRT_CYC) ? POR_CYC : PWRT_CYC;
  localparam int MAXC = (M1 > FSCM_CYC) ? M1 : FSCM_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] POR_LAST  = CW'(POR_CYC - 1);
  localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_CYC - 1);
  localparam logic [CW-1:0] FSCM_LAST = CW'(FSCM_CYC - 1);

  rrs_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_last;
  logic          skip_mid;
  logic          trap_q;

  always_comb begin
    if (state_q == ST_POR) cnt_last = POR_LAST;
    else if (pwrt_en_i)    cnt_last = PWRT_LAST;
    else                   cnt_last = FSCM_LAST;
  end

  assign skip_mid   = !pwrt_en_i && !xtal_i;
  assign trap_set_o = (state_q == ST_WAIT) && !clk_ready_i && fscm_en_i && !bor_i;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      state_q <= ST_POR;
      cnt_q   <= '0;
      trap_q  <= 1'b0;
    end else begin
      trap_q <= trap_set_o;
      if (bor_i) begin
        state_q <= ST_POR;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_POR: begin
            if (cnt_q == cnt_last) begin
              cnt_q   <= '0;
              state_q <= skip_mid ? ST_WAIT : ST_PWRT;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PWRT: begin
            if (cnt_q == cnt_last) begin
              cnt_q   <= '0;
              state_q <= ST_WAIT;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_WAIT: if (clk_ready_i || fscm_en_i) state_q <= ST_RUN;
          default: state_q <= ST_RUN;
        endcase
      end
    end
  end

  assign in_reset_o = (state_q != ST_RUN);
  assign trap_o     = trap_q;

  // R7
  trap_single_chk: assert property (@(posedge clk_i) disable iff (por_i)
    trap_o |=> !trap_o);

  // R7
  trap_needs_mon_chk: assert property (@(posedge clk_i) disable iff (por_i)
    trap_o |-> $past(fscm_en_i));

  // R8
  release_cause_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(in_reset_o) |-> ($past(clk_ready_i) || trap_o));

  // R9
  bor_reset_chk: assert property (@(posedge clk_i) disable iff (por_i)
    bor_i |=> in_reset_o);
endmodule

// File: rtl/rrs_status.sv
module rrs_status (
  input  logic clk_i,
  input  logic por_i,
  input  logic bor_i,
  input  logic clr_i,
  input  logic trap_set_i,
  input  logic sel_wr_i,
  input  logic sel_wdata_i,
  output logic stat_por_o,
  output logic stat_bor_o,
  output logic clk_sel_o
);
  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      stat_por_o <= 1'b1;
      stat_bor_o <= 1'b0;
    end else if (bor_i) begin
      stat_bor_o <= 1'b1;
    end else if (clr_i) begin
      stat_por_o <= 1'b0;
      stat_bor_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)           clk_sel_o <= 1'b0;
    else if (bor_i)      clk_sel_o <= 1'b0;
    else if (trap_set_i) clk_sel_o <= 1'b1;
    else if (sel_wr_i)   clk_sel_o <= sel_wdata_i;
  end

  // R10
  bor_sets_chk: assert property (@(posedge clk_i) disable iff (por_i)
    bor_i |=> stat_bor_o);

  // R10
  clr_clears_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (clr_i && !bor_i) |=> (!stat_bor_o && !stat_por_o));

  // R11
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (!bor_i && !trap_set_i && !sel_wr_i) |=> $stable(clk_sel_o));
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq #(
  parameter int POR_CYC  = 64,
  parameter int PWRT_CYC = 2048,
  parameter int FSCM_CYC = 4,
  parameter int OST_CYC  = 1024
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic bor_i,
  input  logic xtal_mode_i,
  input  logic pll_en_i,
  input  logic pwrt_en_i,
  input  logic fscm_en_i,
  input  logic osc_run_i,
  input  logic pll_lock_i,
  input  logic stat_clr_i,
  input  logic clksel_wr_i,
  input  logic clksel_wdata_i,
  output logic rst_int_o,
  output logic sysclk_en_o,
  output logic clk_sel_o,
  output logic trap_o,
  output logic stat_por_o,
  output logic stat_bor_o
);
  logic ost_done;
  logic clk_ready;
  logic trap_set;

  rrs_ost_ctr #(.OST_CYC(OST_CYC)) u_ost (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .restart_i (bor_i),
    .osc_run_i (osc_run_i),
    .done_o    (ost_done)
  );

  assign clk_ready = osc_run_i && (!xtal_mode_i || ost_done) && (!pll_en_i || pll_lock_i);

  rrs_seq_fsm #(
    .POR_CYC  (POR_CYC),
    .PWRT_CYC (PWRT_CYC),
    .FSCM_CYC (FSCM_CYC)
  ) u_fsm (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .bor_i       (bor_i),
    .pwrt_en_i   (pwrt_en_i),
    .xtal_i      (xtal_mode_i),
    .fscm_en_i   (fscm_en_i),
    .clk_ready_i (clk_ready),
    .in_reset_o  (rst_int_o),
    .trap_set_o  (trap_set),
    .trap_o      (trap_o)
  );

  rrs_status u_stat (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .bor_i       (bor_i),
    .clr_i       (stat_clr_i),
    .trap_set_i  (trap_set),
    .sel_wr_i    (clksel_wr_i),
    .sel_wdata_i (clksel_wdata_i),
    .stat_por_o  (stat_por_o),
    .stat_bor_o  (stat_bor_o),
    .clk_sel_o   (clk_sel_o)
  );

  assign sysclk_en_o = clk_sel_o || clk_ready;

  // R7
  trap_fallback_chk: assert property (@(posedge clk_i) disable iff (por_i)
    trap_o |-> (clk_sel_o && !rst_int_o));
endmodule

// File: tb/rst_release_seq_tb.sv
module rst_release_seq_tb;
  localparam int P  = 4;
  localparam int PW = 6;
  localparam int FS = 3;
  localparam int OS = 3;

  logic clk = 1'b0;
  logic por = 1'b1, bor = 1'b0, xtal = 1'b0, pll = 1'b0, pwrt = 1'b0, fscm = 1'b0;
  logic osc = 1'b1, lock = 1'b1, clr = 1'b0, swr = 1'b0, swd = 1'b0;
  logic rst_int, sysclk_en, clk_sel, trap, s_por, s_bor;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_release_seq #(.POR_CYC(P), .PWRT_CYC(PW), .FSCM_CYC(FS), .OST_CYC(OS)) u_dut (
    .clk_i(clk), .por_i(por), .bor_i(bor), .xtal_mode_i(xtal), .pll_en_i(pll),
    .pwrt_en_i(pwrt), .fscm_en_i(fscm), .osc_run_i(osc), .pll_lock_i(lock),
    .stat_clr_i(clr), .clksel_wr_i(swr), .clksel_wdata_i(swd),
    .rst_int_o(rst_int), .sysclk_en_o(sysclk_en), .clk_sel_o(clk_sel),
    .trap_o(trap), .stat_por_o(s_por), .stat_bor_o(s_bor));

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic do_por(input logic x, input logic p, input logic w, input logic f,
                        input logic o, input logic l);
    @(negedge clk);
    por = 1'b1; xtal = x; pll = p; pwrt = w; fscm = f; osc = o; lock = l;
    repeat (2) @(negedge clk);
    por = 1'b0;
  endtask

  task automatic wait_release(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (rst_int && n < 200);
  endtask

  function automatic int exp_rel(input logic x, input logic w);
    return P + (w ? PW : (x ? FS : 0)) + 1;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    // R1 reset state during and right after power-on
    do_por(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R1 rst", rst_int, 1); chk("R1 sel", clk_sel, 0); chk("R1 trap", trap, 0);
    chk("R1 spor", s_por, 1); chk("R1 sbor", s_bor, 0);

    // Sweep every static configuration with a ready clock: R2, R3, R4
    for (int c = 0; c < 16; c++) begin
      logic x, p, w, f;
      x = c[0]; p = c[1]; w = c[2]; f = c[3];
      do_por(x, p, w, f, 1'b1, 1'b1);
      wait_release(n);
      chk(w ? "R2 release" : (x ? "R3 release" : "R4 release"), n, exp_rel(x, w));
      chk("R7 no trap when ready", trap, 0);
      chk("R7 primary kept", clk_sel, 0);
    end

    // R5 crystal start-up gating versus non-crystal
    do_por(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    for (int e = 1; e <= OS; e++) begin
      @(negedge clk);
      chk("R5 ost gate", sysclk_en, (e >= OS) ? 1 : 0);
    end
    do_por(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R5 rc active at once", sysclk_en, 1);
    osc = 1'b0; #1;
    chk("R5 rc follows osc", sysclk_en, 0);

    // R6 PLL lock gating, R8 frozen until lock
    do_por(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 pll gate", sysclk_en, 0);
    repeat (20) @(negedge clk);
    chk("R8 frozen pll", rst_int, 1); chk("R8 no trap", trap, 0);
    lock = 1'b1; #1;
    chk("R6 lock opens", sysclk_en, 1);
    wait_release(n);
    chk("R8 lock release", n, 1);

    // R8 frozen crystal that starts late
    do_por(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    repeat (30) @(negedge clk);
    chk("R8 frozen xtal", rst_int, 1); chk("R8 gated", sysclk_en, 0);
    osc = 1'b1;
    wait_release(n);
    chk("R8 late start release", n, OS + 1);

    // R7 trap on dead crystal, R11 latch and software write
    do_por(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    wait_release(n);
    chk("R7 trap release", n, exp_rel(1'b1, 1'b1));
    chk("R7 trap pulse", trap, 1); chk("R7 fallback", clk_sel, 1); chk("R7 clk on", sysclk_en, 1);
    @(negedge clk);
    chk("R7 pulse ends", trap, 0);
    repeat (5) @(negedge clk);
    chk("R11 latch holds", clk_sel, 1);
    swr = 1'b1; swd = 1'b0;
    @(negedge clk); swr = 1'b0;
    chk("R11 write primary", clk_sel, 0); chk("R11 dead primary gated", sysclk_en, 0);
    swr = 1'b1; swd = 1'b1;
    @(negedge clk); swr = 1'b0;
    chk("R11 write fallback", clk_sel, 1);

    // R9 brown-out from the fallback running state
    bor = 1'b1;
    @(negedge clk); bor = 1'b0;
    chk("R9 reset", rst_int, 1); chk("R9 primary", clk_sel, 0); chk("R9 sbor", s_bor, 1);

    // R7 trap on missing PLL lock, fast path
    do_por(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    wait_release(n);
    chk("R7 pll trap release", n, P + 1); chk("R7 pll trap", trap, 1);

    // R10 clear, R9 brown-out restart timing with OST restart
    do_por(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    wait_release(n);
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk("R10 clr por", s_por, 0); chk("R10 clr bor", s_bor, 0);
    bor = 1'b1;
    @(posedge clk);
    @(negedge clk); bor = 1'b0;
    chk("R9 bor reset", rst_int, 1); chk("R9 ost restarted", sysclk_en, 0);
    chk("R9 sbor set", s_bor, 1); chk("R9 spor kept", s_por, 0);
    wait_release(n);
    chk("R9 bor release", n + 1, P + PW + 2);

    // R10 brown-out wins over clear in the same cycle
    bor = 1'b1; clr = 1'b1;
    @(negedge clk); bor = 1'b0; clr = 1'b0;
    chk("R10 bor beats clr", s_bor, 1);

    finish_run();
  end
endmodule